// File: doc/BRIEF.md
# ARINC 429 Channel Host Word Interface

This block sits between a 16-bit host data bus and one channel of an ARINC 429 transceiver. The channel has a configurable number of receivers (two by default) and one transmitter. Every word it carries is 32 bits wide, and the host moves each word as two 16-bit halves. Serial line coding is outside the block. A receiver hands over a finished word as a parallel 32-bit value with a one-cycle valid pulse. The block hands the transmit serializer a 32-bit word together with a one-cycle load pulse.

The block decodes fixed host offsets into read enables for each receiver and drives a half-select line that tells which half is being read. It keeps a data-ready flag and a sticky overrun flag for each receiver. It freezes the upper half when the lower half is read, so that the two reads always belong to one word. It builds the transmit word from an ordered pair of writes. It also holds a channel control word. One bit of that word sets the receive rate for every receiver of the channel. Host reads are registered: the read data appears on the bus the cycle after the read strobe.

Top module: `hwi_arinc_host`

## Requirements
- R1: Offset 0x40 returns receiver 1 bits 15..0 and offset 0x42 returns bits 31..16. Offsets 0x44 and 0x46 do the same for receiver 2. The data appears on `bus_rdata` one cycle after the read strobe.
- R2: A read at either half of receiver n raises the same single bit `rx_rd_en[n]`. `half_sel` is 1 only for the upper-half offset and 0 for the lower-half offset. `half_sel` is never 1 unless some `rx_rd_en` bit is 1.
- R3: Reading the upper half clears that receiver's `rx_ready` bit. Reading the lower half leaves the bit as it was.
- R4: An upper-half read that follows a lower-half read returns the upper half of the word that the lower read came from, even if a new word arrived between the two reads.
- R5: A word arriving sets `rx_ready` and replaces the buffered word. If `rx_ready` was already set, and the same cycle is not an upper-half read of that receiver, the sticky overrun flag is set. A word arriving in the same cycle as an upper-half read leaves `rx_ready` at 1 and does not set overrun.
- R6: A read at offset 0x4C returns a status word laid out as follows: overrun flags in bits 15..14 (receiver 2 in bit 15), ready flags in bits 13..12 (receiver 2 in bit 13), zeros in bits 11..8, and the control word in bits 7..0. The read clears all overrun flags.
- R7: A write at 0x48 (lower half) followed by a write at 0x4A (upper half) sets `tx_word` to {upper, lower}. `tx_load` is high for exactly one cycle, in the cycle after the upper write.
- R8: An upper-half transmit write that is not preceded by a lower-half write, counted since the last load, is ignored: `tx_load` stays 0 and `tx_word` is unchanged. When two lower writes come in a row, the later one is used.
- R9: A write at 0x4C stores bus bits 7..0 into `ctrl_word`. Bit 0 of the control word drives `rx_rate_hi`, which applies to all receivers.
- R10: Reads at the write-only transmit offsets, and at unmapped offsets, return 0. Writes at receiver offsets have no effect.
- R11: After reset, `rx_ready`, the overrun flags, `ctrl_word`, `tx_word`, `tx_load` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Host byte offset |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered host read data |
| rx_valid | input | 2 | Word-arrival pulse, one bit per receiver |
| rx_word | input | 64 | Arriving words; receiver n occupies bits 32n+31..32n |
| rx_ready | output | 2 | Data-ready flag per receiver |
| rx_rd_en | output | 2 | Read enable per receiver, asserted during the host read |
| half_sel | output | 1 | 1 when the upper half is being read |
| rx_rate_hi | output | 1 | Shared receive rate select |
| ctrl_word | output | 8 | Channel control word |
| tx_word | output | 32 | Assembled transmit word |
| tx_load | output | 1 | One-cycle load pulse to the serializer |

## Verification
The sensitive case is a host upper-half read that lands in the same cycle as a word arrival at the same receiver. Both events act on the ready flag and the buffer. The bench raises the valid pulse and the upper-read strobe on the same clock edge. It then expects three things: the read returns the old word's upper half, ready stays set, and the status word shows no overrun. Follow-up reads must then return the new word. A second case is an arrival between a lower read and its upper read. The upper half must come from the frozen copy, and the status word must report the overrun.

// File: rtl/hwi_pkg.sv
package hwi_pkg;
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_RX_LO,
      ACC_RX_HI,
      ACC_TX_LO,
      ACC_TX_HI,
      ACC_CTRL
   } hwi_acc_e;
endpackage

// File: rtl/hwi_addr_decode.sv
module hwi_addr_decode #(
   parameter int ADDR_W = 8,
   parameter int BASE   = 'h40,
   parameter int NUM_RX = 2
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [NUM_RX-1:0] rd_rx,
   output logic              rd_upper,
   output logic              rd_ctrl,
   output logic              wr_tx_lo,
   output logic              wr_tx_hi,
   output logic              wr_ctrl
);
   import hwi_pkg::*;

   localparam logic [ADDR_W-1:0] TX_LO_A = ADDR_W'(BASE + 4*NUM_RX);
   localparam logic [ADDR_W-1:0] TX_HI_A = ADDR_W'(BASE + 4*NUM_RX + 2);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(BASE + 4*NUM_RX + 4);

   logic [NUM_RX-1:0] hit_lo;
   logic [NUM_RX-1:0] hit_hi;
   hwi_acc_e          kind;

   for (genvar i = 0; i < NUM_RX; i++) begin : g_rx_hit
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE + 4*i);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + 4*i + 2);
      assign hit_lo[i] = (bus_addr == LO_A);
      assign hit_hi[i] = (bus_addr == HI_A);
   end

   always_comb begin
      kind = ACC_NONE;
      if (|hit_lo)                 kind = ACC_RX_LO;
      else if (|hit_hi)            kind = ACC_RX_HI;
      else if (bus_addr == TX_LO_A) kind = ACC_TX_LO;
      else if (bus_addr == TX_HI_A) kind = ACC_TX_HI;
      else if (bus_addr == CTRL_A)  kind = ACC_CTRL;
   end

   assign rd_rx    = bus_rd ? (hit_lo | hit_hi) : '0;
   assign rd_upper = bus_rd && (kind == ACC_RX_HI);
   assign rd_ctrl  = bus_rd && (kind == ACC_CTRL);
   assign wr_tx_lo = bus_wr && (kind == ACC_TX_LO);
   assign wr_tx_hi = bus_wr && (kind == ACC_TX_HI);
   assign wr_ctrl  = bus_wr && (kind == ACC_CTRL);
endmodule

// File: rtl/hwi_rx_slot.sv
module hwi_rx_slot #(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              rd_lo,
   input  logic              rd_hi,
   input  logic              ovr_clr,
   output logic              ready,
   output logic              overrun,
   output logic [HALF_W-1:0] lo_half,
   output logic [HALF_W-1:0] hi_half
);
   logic [WORD_W-1:0] word_q;
   logic [HALF_W-1:0] hi_shadow_q;
   logic              lo_seen_q;
   logic              ready_q;
   logic              ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q      <= '0;
         hi_shadow_q <= '0;
         lo_seen_q   <= 1'b0;
         ready_q     <= 1'b0;
         ovr_q       <= 1'b0;
      end else begin
         if (in_valid) word_q <= in_word;

         if (in_valid)   ready_q <= 1'b1;
         else if (rd_hi) ready_q <= 1'b0;

         if (in_valid && ready_q && !rd_hi) ovr_q <= 1'b1;
         else if (ovr_clr)                  ovr_q <= 1'b0;

         if (rd_lo) begin
            hi_shadow_q <= word_q[WORD_W-1:HALF_W];
            lo_seen_q   <= 1'b1;
         end else if (rd_hi) begin
            lo_seen_q   <= 1'b0;
         end
      end
   end

   assign ready   = ready_q;
   assign overrun = ovr_q;
   assign lo_half = word_q[HALF_W-1:0];
   assign hi_half = lo_seen_q ? hi_shadow_q : word_q[WORD_W-1:HALF_W];
endmodule

// File: rtl/hwi_tx_pack.sv
module hwi_tx_pack #(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [WORD_W-1:0] word,
   output logic              load
);
   logic [HALF_W-1:0] lo_q;
   logic              armed_q;
   logic [WORD_W-1:0] word_q;
   logic              load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         armed_q <= 1'b0;
         word_q  <= '0;
         load_q  <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (wr_hi && armed_q) begin
            word_q  <= {wdata, lo_q};
            load_q  <= 1'b1;
            armed_q <= 1'b0;
         end else if (wr_lo) begin
            lo_q    <= wdata;
            armed_q <= 1'b1;
         end
      end
   end

   assign word = word_q;
   assign load = load_q;
endmodule

// File: rtl/hwi_arinc_host.sv
module hwi_arinc_host #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int NUM_RX   = 2,
   parameter int CTRL_W   = 8,
   parameter int RATE_BIT = 0,
   parameter int BASE     = 'h40,
   localparam int WORD_W  = 2 * DATA_W,
   localparam int PAD_W   = DATA_W - 2*NUM_RX - CTRL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_RX-1:0]        rx_valid,
   input  logic [NUM_RX*WORD_W-1:0] rx_word,
   output logic [NUM_RX-1:0]        rx_ready,
   output logic [NUM_RX-1:0]        rx_rd_en,
   output logic                     half_sel,
   output logic                     rx_rate_hi,
   output logic [CTRL_W-1:0]        ctrl_word,
   output logic [WORD_W-1:0]        tx_word,
   output logic                     tx_load
);
   if (NUM_RX < 1) begin : g_bad_rx
      $error("hwi_arinc_host: NUM_RX must be at least 1");
   end
   if (PAD_W < 1) begin : g_bad_status
      $error("hwi_arinc_host: status word cannot hold flags and control");
   end
   if (RATE_BIT >= CTRL_W) begin : g_bad_rate
      $error("hwi_arinc_host: RATE_BIT outside control word");
   end
   if (BASE % 2 != 0 || BASE + 4*NUM_RX + 4 >= (1 << ADDR_W)) begin : g_bad_base
      $error("hwi_arinc_host: BASE misaligned or map exceeds address space");
   end

   logic [NUM_RX-1:0] rd_rx;
   logic              rd_upper, rd_ctrl, wr_tx_lo, wr_tx_hi, wr_ctrl;
   logic [NUM_RX-1:0] ovr;
   logic [DATA_W-1:0] lo_half [NUM_RX];
   logic [DATA_W-1:0] hi_half [NUM_RX];
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;

   hwi_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_RX(NUM_RX)) u_dec (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .rd_rx    (rd_rx),
      .rd_upper (rd_upper),
      .rd_ctrl  (rd_ctrl),
      .wr_tx_lo (wr_tx_lo),
      .wr_tx_hi (wr_tx_hi),
      .wr_ctrl  (wr_ctrl)
   );

   for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
      hwi_rx_slot #(.WORD_W(WORD_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (rx_valid[i]),
         .in_word  (rx_word[i*WORD_W +: WORD_W]),
         .rd_lo    (rd_rx[i] && !rd_upper),
         .rd_hi    (rd_rx[i] && rd_upper),
         .ovr_clr  (rd_ctrl),
         .ready    (rx_ready[i]),
         .overrun  (ovr[i]),
         .lo_half  (lo_half[i]),
         .hi_half  (hi_half[i])
      );
   end

   hwi_tx_pack #(.HALF_W(DATA_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_tx_lo),
      .wr_hi (wr_tx_hi),
      .wdata (bus_wdata),
      .word  (tx_word),
      .load  (tx_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_RX; i++) begin
         if (rd_rx[i]) rd_val = rd_upper ? hi_half[i] : lo_half[i];
      end
      if (rd_ctrl) rd_val = {ovr, rx_ready, {PAD_W{1'b0}}, ctrl_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_val;
   end

   assign bus_rdata  = rdata_q;
   assign rx_rd_en   = rd_rx;
   assign half_sel   = rd_upper;
   assign ctrl_word  = ctrl_q;
   assign rx_rate_hi = ctrl_q[RATE_BIT];
endmodule

// File: rtl/hwi_arinc_host_chk.sv
module hwi_arinc_host_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int NUM_RX   = 2,
   parameter int CTRL_W   = 8,
   parameter int BASE     = 'h40,
   localparam int WORD_W  = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NUM_RX-1:0] rx_valid,
   input logic [NUM_RX-1:0] rx_ready,
   input logic [NUM_RX-1:0] rx_rd_en,
   input logic              half_sel,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [WORD_W-1:0] tx_word,
   input logic              tx_load
);
   localparam logic [ADDR_W-1:0] TX_HI_A = ADDR_W'(BASE + 4*NUM_RX + 2);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(BASE + 4*NUM_RX + 4);

   p_one_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_rd_en));
   p_sel_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      half_sel |-> (|rx_rd_en));

   for (genvar i = 0; i < NUM_RX; i++) begin : g_rx_chk
      p_upper_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_rd_en[i] && half_sel && !rx_valid[i]) |=> !rx_ready[i]);
      p_lower_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_rd_en[i] && !half_sel && !rx_valid[i]) |=> $stable(rx_ready[i]));
      p_arrival_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
         rx_valid[i] |=> rx_ready[i]);
   end

   p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);
   p_load_after_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> $past(bus_wr && bus_addr == TX_HI_A));
   p_word_moves_with_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_word) |-> tx_load);
   p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_A) |=> ctrl_word == $past(bus_wdata[CTRL_W-1:0]));
endmodule

bind hwi_arinc_host hwi_arinc_host_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RX(NUM_RX), .CTRL_W(CTRL_W), .BASE(BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_rd_en  (rx_rd_en),
   .half_sel  (half_sel),
   .ctrl_word (ctrl_word),
   .tx_word   (tx_word),
   .tx_load   (tx_load)
);

// File: tb/sim_hwi_arinc_host.sv
`timescale 1ns/1ps
module sim_hwi_arinc_host;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  rx_valid = '0;
   logic [63:0] rx_word = '0;
   logic [1:0]  rx_ready;
   logic [1:0]  rx_rd_en;
   logic        half_sel;
   logic        rx_rate_hi;
   logic [7:0]  ctrl_word;
   logic [31:0] tx_word;
   logic        tx_load;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   hwi_arinc_host u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_ready(rx_ready), .rx_rd_en(rx_rd_en), .half_sel(half_sel), .rx_rate_hi(rx_rate_hi),
      .ctrl_word(ctrl_word), .tx_word(tx_word), .tx_load(tx_load)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops the expected read data one cycle after each read strobe
   always @(posedge clk) begin
      automatic logic seen = bus_rd;
      #1;
      if (seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic host_rd(input logic [7:0] a, input logic [15:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic push_rx(input int n, input logic [31:0] w);
      rx_word[n*32 +: 32] = w; rx_valid[n] = 1'b1;
      @(negedge clk);
      rx_valid = '0;
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 ready", rx_ready, 0);
      check("R11 load", tx_load, 0);
      check("R11 ctrl", ctrl_word, 0);
      check("R11 rdata", bus_rdata, 0);
      check("R11 txword", tx_word, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R3 basic receiver 1 read
      push_rx(0, 32'hA5A5_1234);
      check("R5 ready set", rx_ready, 2'b01);
      host_rd(8'h40, 16'h1234, "R1 rx1 lower");
      check("R3 lower keeps ready", rx_ready, 2'b01);
      host_rd(8'h42, 16'hA5A5, "R1 rx1 upper");
      check("R3 upper clears ready", rx_ready, 2'b00);

      // R2 enables and half select, checked without a clock edge
      bus_addr = 8'h46; bus_rd = 1'b1; #0.5;
      check("R2 rden upper", rx_rd_en, 2'b10);
      check("R2 sel upper", half_sel, 1'b1);
      bus_addr = 8'h44; #0.5;
      check("R2 rden lower", rx_rd_en, 2'b10);
      check("R2 sel lower", half_sel, 1'b0);
      bus_addr = 8'h48; #0.5;
      check("R2 no rden on tx offset", {rx_rd_en, half_sel}, 3'b000);
      bus_rd = 1'b0;
      @(negedge clk);

      // R4 word arrives between lower and upper reads
      push_rx(1, 32'h1111_2222);
      host_rd(8'h44, 16'h2222, "R4 rx2 lower");
      push_rx(1, 32'h3333_4444);
      host_rd(8'h46, 16'h1111, "R4 rx2 upper from frozen copy");
      check("R3 rx2 cleared", rx_ready, 2'b00);
      host_rd(8'h4C, 16'h8000, "R6 status overrun rx2");
      host_rd(8'h4C, 16'h0000, "R6 overrun cleared by status read");

      // R5 plain overrun on receiver 1
      push_rx(0, 32'hCAFE_0001);
      push_rx(0, 32'hBEAD_0002);
      host_rd(8'h40, 16'h0002, "R5 newer word lower");
      host_rd(8'h42, 16'hBEAD, "R5 newer word upper");
      host_rd(8'h4C, 16'h4000, "R5 overrun rx1 in status");

      // R5 arrival in the same cycle as an upper read
      push_rx(0, 32'h7777_8888);
      rx_word[31:0] = 32'h9999_AAAA; rx_valid[0] = 1'b1;
      host_rd(8'h42, 16'h7777, "R5 same-cycle upper returns old word");
      rx_valid = '0;
      check("R5 same-cycle ready stays", rx_ready, 2'b01);
      host_rd(8'h4C, 16'h1000, "R5 same-cycle no overrun");
      host_rd(8'h40, 16'hAAAA, "R5 same-cycle new lower");
      host_rd(8'h42, 16'h9999, "R5 same-cycle new upper");

      // R10 write-only / unmapped reads and writes to read offsets
      host_rd(8'h48, 16'h0000, "R10 tx lower offset reads zero");
      host_rd(8'h4A, 16'h0000, "R10 tx upper offset reads zero");
      host_rd(8'h50, 16'h0000, "R10 unmapped reads zero");
      push_rx(0, 32'h5555_6666);
      host_wr(8'h40, 16'hFFFF);
      host_wr(8'h42, 16'hFFFF);
      check("R10 write to rx offset keeps ready", rx_ready, 2'b01);
      check("R10 write to rx offset no load", tx_load, 1'b0);
      host_rd(8'h40, 16'h6666, "R10 rx lower unchanged");
      host_rd(8'h42, 16'h5555, "R10 rx upper unchanged");

      // R7 transmit assembly
      host_wr(8'h48, 16'hBEEF);
      check("R7 no load after lower", tx_load, 1'b0);
      host_wr(8'h4A, 16'hDEAD);
      check("R7 load pulse", tx_load, 1'b1);
      check("R7 word", tx_word, 32'hDEAD_BEEF);
      @(negedge clk);
      check("R7 load one cycle", tx_load, 1'b0);

      // R8 upper without lower ignored; later lower wins
      host_wr(8'h4A, 16'h1234);
      check("R8 lone upper no load", tx_load, 1'b0);
      check("R8 lone upper word kept", tx_word, 32'hDEAD_BEEF);
      host_wr(8'h48, 16'h1111);
      host_wr(8'h48, 16'h2222);
      host_wr(8'h4A, 16'h3333);
      check("R8 later lower used", tx_word, 32'h3333_2222);
      check("R8 load", tx_load, 1'b1);

      // R9 control word and shared rate bit
      host_wr(8'h4C, 16'hFFA5);
      check("R9 ctrl stored", ctrl_word, 8'hA5);
      check("R9 rate high", rx_rate_hi, 1'b1);
      host_rd(8'h4C, 16'h00A5, "R6 status shows ctrl");
      host_wr(8'h4C, 16'h0034);
      check("R9 rate low", rx_rate_hi, 1'b0);

      repeat (3) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule